// File: doc/BRIEF.md
# DMA Channel Autoinitialization Context Controller

This block holds the two register sets of a display-feed DMA channel. Software writes a programmable shadow set one register at a time. The active set drives the data mover and is presented on `active_ctx`. The channel is started from idle with a kick pulse. That pulse copies the shadow set into the active set and issues a transfer-start pulse.

Each time the data mover reports a finished transfer, the block makes one of three choices:

- copy the shadow set into the active set and start again;
- start again with the active set unchanged;
- stop.

The choice depends on the autoinit enable, the repeat bit, the programming model bit and a self-clearing end-of-programming flag. The data mover, the bus interface and interrupt generation sit outside this block.

The programming model bit selects between two models. In the dual-set model, the end-of-programming flag decides whether a new context is loaded. In the legacy model, the repeat bit alone decides: it either reloads from the shadow set on every completion or stops.

Top module: `ctx_reload_ctrl`

## Requirements
- R1: In the dual-set model (`dual_set_en`=1) with `autoinit_en`=1, a `xfer_done` while busy with the flag at 1 copies every shadow register into the active set. `xfer_start` rises on the next cycle.
- R2: The end-of-programming flag clears itself in the same cycle in which that R1 load happens.
- R3: In the dual-set model with autoinit on, flag 0 and `repeat_en`=1, `xfer_done` restarts the channel. `active_ctx` stays unchanged.
- R4: In the dual-set model with autoinit on, flag 0 and `repeat_en`=0, `xfer_done` drops `busy`. No start is issued and `active_ctx` is unchanged.
- R5: With `autoinit_en`=0, `xfer_done` drops `busy` and issues no start. The flag has no effect on this and keeps its value.
- R6: In the legacy model (`dual_set_en`=0) with autoinit on, `xfer_done` works as follows:
  - with `repeat_en`=1 it reloads the active set from the shadow set and restarts;
  - with `repeat_en`=0 it stops.
  - In both cases the flag has no effect and keeps its value.
- R7: Shadow writes never change `active_ctx` by themselves. A write in the same cycle as a reload lands in the shadow set only after the copy, so the copy takes the old value.
- R8: `xfer_start` is a single-cycle pulse. It is asserted exactly one cycle after the `kick` or `xfer_done` that caused it.
- R9: If `eop_set` and the hardware clear fall in the same cycle, the flag ends at 0.
- R10: A `kick` while idle loads the shadow set and starts the channel. A `kick` while busy is ignored, and so is an `xfer_done` while idle.
- R11: After reset, `active_ctx`, the shadow set, `eop_flag`, `busy` and `xfer_start` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | SEL_W | Shadow register index; register k occupies bits k*DATA_W upward of `active_ctx` |
| wr_data | input | DATA_W | Shadow register write data |
| eop_set | input | 1 | Software pulse that sets the end-of-programming flag |
| autoinit_en | input | 1 | Autoinitialization enable |
| repeat_en | input | 1 | Repeat bit |
| dual_set_en | input | 1 | 1 selects the dual-set model, 0 the legacy model |
| kick | input | 1 | Start the channel from idle |
| xfer_done | input | 1 | Transfer-complete pulse from the data mover |
| active_ctx | output | NREG*DATA_W | Active register set |
| xfer_start | output | 1 | Transfer-start pulse |
| busy | output | 1 | Channel has a transfer outstanding |
| eop_flag | output | 1 | End-of-programming flag, readable |

## Verification
A wrong decision shows on the very next cycle. Three things can go wrong there: a missing or extra `xfer_start`, a `busy` that falls or stays high wrongly, or an `active_ctx` that changed or failed to change. A corrupted shadow register stays hidden until the next reload copies it out, so the bench reloads after every shadow write pattern, including a write that coincides with a reload. A flag that fails to clear shows at `eop_flag` one cycle after the load, and again as an unwanted reload at the following completion.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
   typedef enum logic [1:0] {
      DEC_IDLE   = 2'd0,
      DEC_LOAD   = 2'd1,
      DEC_REPEAT = 2'd2,
      DEC_STOP   = 2'd3
   } reload_dec_t;
endpackage

// File: rtl/ctx_shadow_regs.sv
module ctx_shadow_regs #(
   parameter int NREG         = 6,
   parameter int DATA_W       = 32,
   parameter bit RESET_SHADOW = 1'b1,
   localparam int SEL_W       = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SEL_W-1:0]         wr_sel,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [NREG*DATA_W-1:0]   shadow
);
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic hit;
      assign hit = wr_en && (wr_sel == SEL_W'(g));
      if (RESET_SHADOW) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)   shadow[g*DATA_W +: DATA_W] <= '0;
            else if (hit) shadow[g*DATA_W +: DATA_W] <= wr_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) shadow[g*DATA_W +: DATA_W] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/ctx_active_regs.sv
module ctx_active_regs #(
   parameter int NREG   = 6,
   parameter int DATA_W = 32,
   localparam int TOT_W = NREG * DATA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TOT_W-1:0] shadow,
   output logic [TOT_W-1:0] active
);
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)    active[g*DATA_W +: DATA_W] <= '0;
         else if (load) active[g*DATA_W +: DATA_W] <= shadow[g*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/ctx_reload_fsm.sv
module ctx_reload_fsm
   import ctx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        kick,
   input  logic        xfer_done,
   input  logic        autoinit_en,
   input  logic        repeat_en,
   input  logic        dual_set_en,
   input  logic        eop_set,
   output reload_dec_t dec,
   output logic        xfer_start,
   output logic        busy,
   output logic        eop_flag
);
   logic done_ok, eop_clr, go;

   assign done_ok = xfer_done && busy;
   assign eop_clr = done_ok && autoinit_en && dual_set_en && eop_flag;
   assign go      = (dec == DEC_LOAD) || (dec == DEC_REPEAT);

   always_comb begin
      dec = DEC_IDLE;
      if (kick && !busy) begin
         dec = DEC_LOAD;
      end else if (done_ok) begin
         if (!autoinit_en)     dec = DEC_STOP;
         else if (dual_set_en) dec = eop_flag  ? DEC_LOAD :
                                     repeat_en ? DEC_REPEAT : DEC_STOP;
         else                  dec = repeat_en ? DEC_LOAD : DEC_STOP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_start <= 1'b0;
         busy       <= 1'b0;
         eop_flag   <= 1'b0;
      end else begin
         xfer_start <= go;
         if (go)                    busy <= 1'b1;
         else if (dec == DEC_STOP)  busy <= 1'b0;
         if (eop_clr)               eop_flag <= 1'b0;
         else if (eop_set)          eop_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/ctx_reload_ctrl.sv
module ctx_reload_ctrl
   import ctx_pkg::*;
#(
   parameter int NREG         = 6,
   parameter int DATA_W       = 32,
   parameter bit RESET_SHADOW = 1'b1,
   localparam int SEL_W       = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int TOT_W       = NREG * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              eop_set,
   input  logic              autoinit_en,
   input  logic              repeat_en,
   input  logic              dual_set_en,
   input  logic              kick,
   input  logic              xfer_done,
   output logic [TOT_W-1:0]  active_ctx,
   output logic              xfer_start,
   output logic              busy,
   output logic              eop_flag
);
   if (NREG < 1)   begin : g_bad_nreg  $error("NREG must be at least 1");   end
   if (DATA_W < 1) begin : g_bad_width $error("DATA_W must be at least 1"); end

   logic [TOT_W-1:0] shadow_q;
   reload_dec_t      dec;

   ctx_shadow_regs #(.NREG(NREG), .DATA_W(DATA_W), .RESET_SHADOW(RESET_SHADOW)) u_shadow (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .shadow(shadow_q)
   );

   ctx_reload_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .kick(kick), .xfer_done(xfer_done),
      .autoinit_en(autoinit_en), .repeat_en(repeat_en), .dual_set_en(dual_set_en),
      .eop_set(eop_set), .dec(dec), .xfer_start(xfer_start), .busy(busy),
      .eop_flag(eop_flag)
   );

   ctx_active_regs #(.NREG(NREG), .DATA_W(DATA_W)) u_active (
      .clk(clk), .rst_n(rst_n), .load(dec == DEC_LOAD),
      .shadow(shadow_q), .active(active_ctx)
   );
endmodule

// File: rtl/ctx_reload_chk.sv
module ctx_reload_chk #(
   parameter int NREG   = 6,
   parameter int DATA_W = 32,
   localparam int TOT_W = NREG * DATA_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             kick,
   input logic             xfer_done,
   input logic             autoinit_en,
   input logic             repeat_en,
   input logic             dual_set_en,
   input logic             eop_set,
   input logic [TOT_W-1:0] shadow_q,
   input logic [TOT_W-1:0] active_ctx,
   input logic             xfer_start,
   input logic             busy,
   input logic             eop_flag
);
   logic dual_load_c, dual_rep_c, quiet_c;
   assign dual_load_c = busy && xfer_done && autoinit_en && dual_set_en && eop_flag;
   assign dual_rep_c  = busy && xfer_done && autoinit_en && dual_set_en && !eop_flag && repeat_en;
   assign quiet_c     = !(busy && xfer_done) && !(kick && !busy);

   AST_DUAL_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      dual_load_c |=> (active_ctx == $past(shadow_q)) && xfer_start); // R1
   AST_EOP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      dual_load_c |=> !eop_flag); // R2
   AST_REPEAT_SAME_CTX: assert property (@(posedge clk) disable iff (!rst_n)
      dual_rep_c |=> xfer_start && $stable(active_ctx)); // R3
   AST_NOINIT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && xfer_done && !autoinit_en) |=> !xfer_start && !busy); // R5
   AST_NOINIT_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && xfer_done && !autoinit_en && !eop_set) |=> $stable(eop_flag)); // R5
   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      quiet_c |=> $stable(active_ctx)); // R7
   AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> $past(xfer_done || kick)); // R8
   AST_SET_CLEAR_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      (dual_load_c && eop_set) |=> !eop_flag); // R9
endmodule

bind ctx_reload_ctrl ctx_reload_chk #(.NREG(NREG), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .kick(kick), .xfer_done(xfer_done),
   .autoinit_en(autoinit_en), .repeat_en(repeat_en), .dual_set_en(dual_set_en),
   .eop_set(eop_set), .shadow_q(shadow_q), .active_ctx(active_ctx),
   .xfer_start(xfer_start), .busy(busy), .eop_flag(eop_flag)
);

// File: tb/test_ctx_reload_ctrl.sv
module test_ctx_reload_ctrl;
   localparam int NREG = 6;
   localparam int DW   = 32;
   localparam int SW   = $clog2(NREG);

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 0, eop_set = 0, autoinit_en = 0, repeat_en = 0, dual_set_en = 1, kick = 0, xfer_done = 0;
   logic [SW-1:0] wr_sel = '0;
   logic [DW-1:0] wr_data = '0;
   logic [NREG*DW-1:0] active_ctx;
   logic xfer_start, busy, eop_flag;

   always #10 clk = ~clk;

   ctx_reload_ctrl #(.NREG(NREG), .DATA_W(DW)) i_ctx_reload_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .eop_set(eop_set), .autoinit_en(autoinit_en), .repeat_en(repeat_en),
      .dual_set_en(dual_set_en), .kick(kick), .xfer_done(xfer_done),
      .active_ctx(active_ctx), .xfer_start(xfer_start), .busy(busy), .eop_flag(eop_flag)
   );

   int n_chk = 0, n_fail = 0;
   string cur_req = "R11";

   // Behavioural reference model
   logic [DW-1:0] m_act[NREG], m_sh[NREG];
   bit m_eop, m_busy, m_start;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_act[i]) begin m_act[i] = '0; m_sh[i] = '0; end
         m_eop = 0; m_busy = 0; m_start = 0;
      end else begin
         bit ns, clr;
         ns = 0; clr = 0;
         if (kick && !m_busy) begin
            m_act = m_sh; ns = 1;
         end else if (xfer_done && m_busy) begin
            if (!autoinit_en) m_busy = 0;
            else if (dual_set_en) begin
               if (m_eop) begin m_act = m_sh; clr = 1; ns = 1; end
               else if (repeat_en) ns = 1;
               else m_busy = 0;
            end else begin
               if (repeat_en) begin m_act = m_sh; ns = 1; end
               else m_busy = 0;
            end
         end
         if (ns) m_busy = 1;
         if (clr) m_eop = 0;
         else if (eop_set) m_eop = 1;
         if (wr_en && wr_sel < NREG) m_sh[wr_sel] = wr_data;
         m_start = ns;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit bad;
         bad = (xfer_start !== m_start) || (busy !== m_busy) || (eop_flag !== m_eop);
         foreach (m_act[i]) if (active_ctx[i*DW +: DW] !== m_act[i]) bad = 1;
         n_chk++;
         if (bad) begin
            n_fail++;
            $display("FAIL %s model: start=%b/%b busy=%b/%b eop=%b/%b act0=%h/%h act1=%h/%h",
                     cur_req, xfer_start, m_start, busy, m_busy, eop_flag, m_eop,
                     active_ctx[0 +: DW], m_act[0], active_ctx[DW +: DW], m_act[1]);
         end
      end
   end

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      wr_en = 0; eop_set = 0; kick = 0; xfer_done = 0;
   endtask

   task automatic wr(input int r, input logic [DW-1:0] d);
      wr_en = 1; wr_sel = SW'(r); wr_data = d; tick();
   endtask

   function automatic logic [DW-1:0] act(input int r);
      return active_ctx[r*DW +: DW];
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 busy", {31'd0, busy}, 0);
      chk("R11 start", {31'd0, xfer_start}, 0);
      chk("R11 active", act(0), 0);
      rst_n = 1; tick();
      cur_req = "R10";
      xfer_done = 1; tick();
      chk("R10 done while idle", {31'd0, xfer_start}, 0);
      for (int r = 0; r < NREG; r++) wr(r, 32'hA0 + r);
      chk("R7 write no effect", act(0), 0);
      kick = 1; tick();
      chk("R10 kick loads", act(3), 32'hA3);
      chk("R8 start pulse", {31'd0, xfer_start}, 1);
      tick();
      chk("R8 start one cycle", {31'd0, xfer_start}, 0);
      wr(0, 32'hB0);
      kick = 1; tick();
      chk("R10 kick while busy", act(0), 32'hA0);
      cur_req = "R3";
      autoinit_en = 1; repeat_en = 1; dual_set_en = 1;
      xfer_done = 1; tick();
      chk("R3 restart", {31'd0, xfer_start}, 1);
      chk("R3 ctx kept", act(0), 32'hA0);
      tick();
      cur_req = "R1";
      eop_set = 1; tick();
      xfer_done = 1; tick();
      chk("R1 load", act(0), 32'hB0);
      chk("R2 self clear", {31'd0, eop_flag}, 0);
      tick();
      cur_req = "R9";
      eop_set = 1; tick();
      eop_set = 1; xfer_done = 1; wr_en = 1; wr_sel = 1; wr_data = 32'hC1; tick();
      chk("R9 clear wins", {31'd0, eop_flag}, 0);
      chk("R7 copy before write", act(1), 32'hA1);
      eop_set = 1; tick();
      xfer_done = 1; tick();
      chk("R7 later reload", act(1), 32'hC1);
      tick();
      cur_req = "R4";
      repeat_en = 0; xfer_done = 1; tick();
      chk("R4 stop", {30'd0, busy, xfer_start}, 0);
      chk("R4 ctx kept", act(1), 32'hC1);
      cur_req = "R5";
      kick = 1; tick();
      autoinit_en = 0; eop_set = 1; wr(2, 32'hD2); tick();
      xfer_done = 1; tick();
      chk("R5 stop", {30'd0, busy, xfer_start}, 0);
      chk("R5 flag kept", {31'd0, eop_flag}, 1);
      chk("R5 no load", act(2), 32'hA2);
      cur_req = "R6";
      dual_set_en = 0; autoinit_en = 1; repeat_en = 1;
      kick = 1; tick();
      wr(4, 32'hE4); tick();
      xfer_done = 1; tick();
      chk("R6 reload", act(4), 32'hE4);
      chk("R6 flag kept", {31'd0, eop_flag}, 1);
      chk("R6 restart", {31'd0, xfer_start}, 1);
      tick();
      repeat_en = 0; xfer_done = 1; tick();
      chk("R6 stop", {30'd0, busy, xfer_start}, 0);
      repeat (3) tick();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule